// File: doc/BRIEF.md
# Dual-Level Overcurrent Supervisor

This block is the digital overcurrent supervisor next to the switching stage of a synchronous step-down converter. Each switching cycle begins with a strobe. Analog comparators outside the block send two flags: a soft (first-level) flag and a hard (second-level) flag. The block turns these flags into gate overrides. A soft event cuts the current cycle short: the high side is forced off and the low side is forced on until the next cycle strobe. If soft events occur in a run of consecutive cycles (four by default), the block trips. A hard event trips it at once.

After a trip the high side stays off. The low side conducts until a release comparator reports that the inductor current has decayed, and then both switches are held off. That latched fault is released only when the arming qualifier drops, which happens when the enable input or the supply-good signal is cycled. The block also tells the sensing front end which switch to measure. It picks the low side while the on-time is too short for a reliable high-side reading, and also while the low side is discharging a tripped output.

Top module: `ocp_guard`

## Requirements
- R1: While `armed` is sampled low, on the next clock `hs_off`, `ls_on`, `fault` and `sense_ls` are all 0, and the consecutive-event count restarts from zero.
- R2: Outside a fault, `sense_ls` equals `short_on` as sampled on the previous clock. During the discharge phase after a trip it is 1. Once both switches are latched off it is 0.
- R3: A soft event outside a fault gives `hs_off`=1 and `ls_on`=1 with `fault`=0 on the next clock. This holds until a clock that samples `cyc_start` without a soft or hard event, after which both overrides are 0.
- R4: Soft events in TRIP_CYCLES (default 4) consecutive switching cycles give `fault`=1, `hs_off`=1 and `ls_on`=1 on the clock after the last of those events.
- R5: A switching cycle with no soft event resets the count, so three event cycles, a clean cycle and three more event cycles do not trip.
- R6: A hard event gives `fault`=1, `hs_off`=1 and `ls_on`=1 on the next clock, whatever the count, and it wins over a soft event sampled on the same clock.
- R7: During the discharge phase, `ls_below_rel`=1 gives `ls_on`=0 on the next clock, with `hs_off`=1 and `fault`=1.
- R8: Once both switches are latched off, `cyc_start`, `oc_soft`, `oc_hard` and `ls_below_rel` have no effect on any output. Only a low `armed` releases the latch.
- R9: Several soft events in one switching cycle count as a single event.
- R10: `ls_below_rel` has no effect outside the discharge phase. A cut-short cycle keeps both overrides at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| armed | input | 1 | Enabled and both supplies above lockout |
| cyc_start | input | 1 | One-clock strobe at the start of each switching cycle |
| oc_soft | input | 1 | First-level overcurrent comparator flag |
| oc_hard | input | 1 | Second-level overcurrent comparator flag |
| short_on | input | 1 | Present on-time is below the high-side sensing minimum |
| ls_below_rel | input | 1 | Low-side current is below the release level |
| hs_off | output | 1 | Force the high-side switch off |
| ls_on | output | 1 | Force the low-side switch on |
| fault | output | 1 | Overcurrent protection has tripped |
| sense_ls | output | 1 | 1 selects low-side current sensing, 0 selects high-side sensing |

## Verification
The bench concentrates on how the consecutive-cycle count behaves at its edges. A run of three event cycles followed by a clean cycle must not trip, and four in a row must. A counter that never cleared would trip in the first case, and one that was off by one would trip early or late. Cycles that carry two soft pulses each are also used: a design that counted pulses instead of cycles would trip after two such cycles. The bench fires soft and hard events on the same clock to expose a priority inversion. It also drives every input while the latch holds, to catch any path that releases the latch other than dropping the arming qualifier. Finally, it asserts the release flag during a cut-short cycle, where a design that decoded it in the wrong phase would drop the low side early.

// File: rtl/ocp_guard.sv
module ocp_guard #(
  parameter int TRIP_CYCLES = 4,
  localparam int CW = $clog2(TRIP_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic armed,
  input  logic cyc_start,
  input  logic oc_soft,
  input  logic oc_hard,
  input  logic short_on,
  input  logic ls_below_rel,
  output logic hs_off,
  output logic ls_on,
  output logic fault,
  output logic sense_ls
);

  typedef enum logic [1:0] {ST_RUN, ST_CUT, ST_DRAIN, ST_HOLD} st_t;

  localparam logic [CW-1:0] LAST = CW'(TRIP_CYCLES - 1);

  st_t           st, st_n;
  logic [CW-1:0] cnt, cnt_n, cnt_base;
  logic          evt, evt_n, evt_cur;
  logic          sns_q;

  assign evt_cur  = cyc_start ? 1'b0 : evt;
  assign cnt_base = (cyc_start && !evt) ? '0 : cnt;

  always_comb begin
    st_n  = st;
    cnt_n = cnt;
    evt_n = evt;
    unique case (st)
      ST_RUN, ST_CUT: begin
        cnt_n = cnt_base;
        evt_n = evt_cur;
        if (cyc_start) st_n = ST_RUN;
        if (oc_hard) begin
          st_n = ST_DRAIN;
        end else if (oc_soft) begin
          evt_n = 1'b1;
          if (!evt_cur) begin
            cnt_n = cnt_base + CW'(1);
            st_n  = (cnt_base >= LAST) ? ST_DRAIN : ST_CUT;
          end else begin
            st_n = ST_CUT;
          end
        end
      end
      ST_DRAIN: if (ls_below_rel) st_n = ST_HOLD;
      ST_HOLD:  st_n = ST_HOLD;
      default:  st_n = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_RUN;
      cnt   <= '0;
      evt   <= 1'b0;
      sns_q <= 1'b0;
    end else if (!armed) begin
      st    <= ST_RUN;
      cnt   <= '0;
      evt   <= 1'b0;
      sns_q <= 1'b0;
    end else begin
      st    <= st_n;
      cnt   <= cnt_n;
      evt   <= evt_n;
      sns_q <= short_on;
    end
  end

  assign hs_off   = (st != ST_RUN);
  assign ls_on    = (st == ST_CUT) || (st == ST_DRAIN);
  assign fault    = (st == ST_DRAIN) || (st == ST_HOLD);
  assign sense_ls = (st == ST_DRAIN) || (sns_q && st != ST_HOLD);

endmodule

// File: rtl/ocp_guard_chk.sv
module ocp_guard_chk (
  input logic clk,
  input logic rst_n,
  input logic armed,
  input logic cyc_start,
  input logic oc_soft,
  input logic oc_hard,
  input logic short_on,
  input logic ls_below_rel,
  input logic hs_off,
  input logic ls_on,
  input logic fault,
  input logic sense_ls
);

  p_disarm_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> (!hs_off && !ls_on && !fault && !sense_ls));

  p_sense_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && short_on && !fault) |=> sense_ls);

  p_cut_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !fault && oc_soft) |=> (hs_off && ls_on));

  p_resume_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !fault && ls_on && cyc_start && !oc_soft && !oc_hard) |=> (!hs_off && !ls_on));

  p_hard_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && oc_hard && !(fault && !ls_on)) |=> (fault && hs_off && ls_on));

  p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && fault && ls_on && ls_below_rel) |=> (fault && hs_off && !ls_on));

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && fault && !ls_on) |=> (fault && hs_off && !ls_on && !sense_ls));

endmodule

bind ocp_guard ocp_guard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .armed(armed), .cyc_start(cyc_start),
  .oc_soft(oc_soft), .oc_hard(oc_hard), .short_on(short_on),
  .ls_below_rel(ls_below_rel), .hs_off(hs_off), .ls_on(ls_on),
  .fault(fault), .sense_ls(sense_ls)
);

// File: tb/sim_ocp_guard.sv
module sim_ocp_guard;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, armed = 1'b0;
  logic cyc_start = 1'b0, oc_soft = 1'b0, oc_hard = 1'b0;
  logic short_on = 1'b0, ls_below_rel = 1'b0;
  logic hs_off, ls_on, fault, sense_ls;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ocp_guard u0 (
    .clk(clk), .rst_n(rst_n), .armed(armed), .cyc_start(cyc_start),
    .oc_soft(oc_soft), .oc_hard(oc_hard), .short_on(short_on),
    .ls_below_rel(ls_below_rel), .hs_off(hs_off), .ls_on(ls_on),
    .fault(fault), .sense_ls(sense_ls)
  );

  // one clock with the given pulses; outputs are stable on return
  task automatic drv(input logic cs, input logic s, input logic h, input logic rel);
    cyc_start = cs; oc_soft = s; oc_hard = h; ls_below_rel = rel;
    @(negedge clk);
    cyc_start = 0; oc_soft = 0; oc_hard = 0; ls_below_rel = 0;
  endtask

  // expected order: hs_off, ls_on, fault, sense_ls
  task automatic chk(input string req, input logic [3:0] exp);
    logic [3:0] act;
    act = {hs_off, ls_on, fault, sense_ls};
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic rearm();
    armed = 0; drv(0, 0, 0, 0);
    armed = 1; drv(0, 0, 0, 0);
  endtask

  task automatic event_cycle();
    drv(1, 0, 0, 0);
    drv(0, 1, 0, 0);
  endtask

  task automatic t_reset();
    chk("R1 reset", 4'b0000);
    armed = 1; drv(0, 0, 0, 0);
    chk("R1 idle armed", 4'b0000);
  endtask

  task automatic t_cut_cycle();
    drv(1, 0, 0, 0);
    drv(0, 1, 0, 0);
    chk("R3 cut", 4'b1100);
    drv(0, 0, 0, 1);
    chk("R10 release ignored in cut", 4'b1100);
    drv(1, 0, 0, 0);
    chk("R3 resume at cycle start", 4'b0000);
    rearm();
  endtask

  task automatic t_multi_pulse();
    for (int i = 0; i < 3; i++) begin
      drv(1, 0, 0, 0);
      drv(0, 1, 0, 0);
      drv(0, 0, 0, 0);
      drv(0, 1, 0, 0);
    end
    chk("R9 pulses counted once", 4'b1100);
    drv(1, 0, 0, 0);
    drv(0, 0, 0, 0);
    chk("R9 clean after multi", 4'b0000);
    rearm();
  endtask

  task automatic t_three_clean();
    for (int i = 0; i < 3; i++) event_cycle();
    chk("R5 three events no trip", 4'b1100);
    drv(1, 0, 0, 0);
    drv(0, 0, 0, 0);
    for (int i = 0; i < 3; i++) event_cycle();
    chk("R5 clean cycle resets count", 4'b1100);
    event_cycle();
    chk("R4 fourth after reset trips", 4'b1111);
    rearm();
  endtask

  task automatic t_four_latch();
    for (int i = 0; i < 3; i++) event_cycle();
    chk("R4 third not tripped", 4'b1100);
    event_cycle();
    chk("R4 fourth trips", 4'b1111);
    drv(1, 0, 0, 0);
    chk("R7 drain holds without release", 4'b1111);
    drv(0, 0, 0, 1);
    chk("R7 release latches off", 4'b1010);
    drv(1, 1, 1, 1);
    chk("R8 latch ignores inputs", 4'b1010);
    short_on = 1;
    drv(1, 0, 0, 0);
    chk("R8 latch ignores short_on", 4'b1010);
    short_on = 0;
    armed = 0; drv(0, 0, 0, 0);
    chk("R1 disarm clears latch", 4'b0000);
    armed = 1; drv(0, 0, 0, 0);
    chk("R1 rearmed idle", 4'b0000);
  endtask

  task automatic t_disarm_count();
    for (int i = 0; i < 3; i++) event_cycle();
    rearm();
    event_cycle();
    chk("R1 disarm restarts count", 4'b1100);
    rearm();
  endtask

  task automatic t_hard();
    drv(1, 0, 0, 0);
    drv(0, 1, 1, 0);
    chk("R6 hard wins over soft", 4'b1111);
    rearm();
    drv(0, 0, 1, 0);
    chk("R6 hard mid cycle", 4'b1111);
    rearm();
  endtask

  task automatic t_sense();
    short_on = 1; drv(0, 0, 0, 0);
    chk("R2 short on-time selects low side", 4'b0001);
    short_on = 0; drv(0, 0, 0, 0);
    chk("R2 normal selects high side", 4'b0000);
    drv(0, 0, 1, 0);
    chk("R2 drain selects low side", 4'b1111);
    drv(0, 0, 0, 1);
    chk("R2 latched sense low", 4'b1010);
    rearm();
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    bad++; total++;
    $display("FAIL watchdog: got hang expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_cut_cycle();
    t_multi_pulse();
    t_three_clean();
    t_four_latch();
    t_disarm_count();
    t_hard();
    t_sense();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule